// File: doc/BRIEF.md
# Data Address Generation Unit

This unit forms the data-memory address for each load or store of an 8-bit microcontroller core. It also keeps the three 16-bit pointer registers that are built from byte pairs at the top of the 32-entry register file. Each cycle the decoder presents an addressing-mode code, a pointer select, a 6-bit immediate field and the second word of a two-word instruction. In the same cycle the unit returns the effective address, the memory region that address falls in, and the write-back value for any pointer the access modifies. A modified pointer takes its new value at the next rising clock edge.

The data space is one flat 16-bit map. The 32 working registers sit at the bottom, the 64 I/O registers come next, and SRAM fills the rest. Every mode can reach any of these regions. Byte writes from the core into register-file indices 26 to 31 load the pointer halves.

Top module: `data_addr_gen`

## Requirements
- R1: After a synchronous reset all three pointers read as 0x0000, so an indirect access through any of them gives effective address 0x0000.
- R2: A byte write with index 26/27 loads the low/high byte of pointer X, 28/29 the low/high byte of Y, and 30/31 the low/high byte of Z. A write to any other index leaves all three pointers unchanged.
- R3: Mode code 0 (direct) gives an effective address equal to the 16-bit second instruction word and asserts no write-back.
- R4: Mode code 1 (indirect) gives an effective address equal to the selected pointer (select 0 = X, 1 = Y, 2 = Z), asserts no write-back, and leaves the pointer unchanged.
- R5: Mode code 2 (indirect with displacement) gives base pointer plus the unsigned 6-bit immediate, modulo 2^16, with only Y or Z as the base. It asserts no write-back.
- R6: Mode code 3 (pre-decrement) gives an effective address of pointer minus one, modulo 2^16. It asserts write-back with that same value for the selected pointer, and the pointer holds that value from the next cycle.
- R7: Mode code 4 (post-increment) gives an effective address equal to the unmodified pointer. It asserts write-back with pointer plus one, modulo 2^16, and the pointer holds that value from the next cycle.
- R8: Mode code 5 (I/O direct) gives an effective address of 0x20 plus the 6-bit immediate and asserts no write-back.
- R9: The region output is 0 for addresses 0x0000–0x001F (registers), 1 for 0x0020–0x005F (I/O) and 2 for 0x0060 and above (SRAM).
- R10: While op_valid is low, write-back stays deasserted and no pointer changes, whatever the mode.
- R11: When a pointer write-back and a byte write hit the same pointer in one cycle, the write-back value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A data access is issued this cycle |
| op_mode | input | 3 | Addressing-mode code (0..5) |
| op_ptr | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| op_imm6 | input | 6 | Displacement or I/O address field |
| op_word2 | input | 16 | Second instruction word (direct address) |
| byte_we | input | 1 | Register-file byte write strobe |
| byte_idx | input | 5 | Register-file index being written |
| byte_wdata | input | 8 | Byte being written |
| ea | output | 16 | Effective data address |
| region | output | 2 | Region of ea: 0 registers, 1 I/O, 2 SRAM |
| wb_en | output | 1 | Pointer write-back is active |
| wb_ptr | output | 2 | Pointer receiving the write-back |
| wb_value | output | 16 | New pointer value |

## Verification
The assertions take for granted that the decoder never issues displacement mode with X as the base, never issues a pointer select of 3 for a mode that uses a pointer, and only issues mode codes 0 to 5 while op_valid is high. The stimulus is built from sweeps over those legal mode and select pairs only. For displacement it selects only Y and Z, and it drives an out-of-range code only while op_valid is low. Inside that space it sweeps every immediate value and every I/O address, and it uses pointer values at the region edges and at both wrap points.

// File: rtl/dag_pkg.sv
package dag_pkg;

    parameter int unsigned AW           = 16;
    parameter int unsigned DW           = 8;
    parameter int unsigned PTR_N        = 3;
    parameter int unsigned IMM_W        = 6;
    parameter int unsigned IDX_W        = 5;
    parameter int unsigned PTR_BASE_IDX = 26;
    parameter int unsigned REG_COUNT    = 32;
    parameter int unsigned IO_COUNT     = 64;

    localparam int unsigned IO_BASE   = REG_COUNT;
    localparam int unsigned SRAM_BASE = REG_COUNT + IO_COUNT;
    localparam int unsigned SEL_W     = $clog2(PTR_N + 1);

    typedef logic [AW-1:0] addr_t;

    typedef enum logic [2:0] {
        AM_DIRECT  = 3'd0,
        AM_IND     = 3'd1,
        AM_DISP    = 3'd2,
        AM_PREDEC  = 3'd3,
        AM_POSTINC = 3'd4,
        AM_IODIR   = 3'd5
    } amode_e;

    typedef enum logic [1:0] {
        PSEL_X = 2'd0,
        PSEL_Y = 2'd1,
        PSEL_Z = 2'd2
    } psel_e;

    typedef enum logic [1:0] {
        RG_REGS = 2'd0,
        RG_IO   = 2'd1,
        RG_SRAM = 2'd2
    } region_e;

    typedef struct packed {
        logic  en;
        psel_e sel;
        addr_t value;
    } wb_t;

    function automatic logic mode_uses_ptr(logic [2:0] m);
        return (m == AM_IND) || (m == AM_DISP) || (m == AM_PREDEC) || (m == AM_POSTINC);
    endfunction

    function automatic region_e region_of(addr_t a);
        if (a < addr_t'(IO_BASE))        return RG_REGS;
        else if (a < addr_t'(SRAM_BASE)) return RG_IO;
        else                             return RG_SRAM;
    endfunction

endpackage

// File: rtl/dag_ptr_bank.sv
module dag_ptr_bank
    import dag_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     byte_we,
    input  logic [IDX_W-1:0]         byte_idx,
    input  logic [DW-1:0]            byte_wdata,
    input  wb_t                      wb_i,
    output logic [PTR_N-1:0][AW-1:0] ptr_q
);

    for (genvar g = 0; g < PTR_N; g++) begin : g_ptr
        localparam int unsigned LO_IDX = PTR_BASE_IDX + 2 * g;
        localparam int unsigned HI_IDX = LO_IDX + 1;

        logic lo_hit, hi_hit, wb_hit;
        assign lo_hit = byte_we && (byte_idx == IDX_W'(LO_IDX));
        assign hi_hit = byte_we && (byte_idx == IDX_W'(HI_IDX));
        assign wb_hit = wb_i.en && (wb_i.sel == psel_e'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[g] <= '0;
            end else if (wb_hit) begin
                ptr_q[g] <= wb_i.value;
            end else if (lo_hit) begin
                ptr_q[g][DW-1:0] <= byte_wdata;
            end else if (hi_hit) begin
                ptr_q[g][AW-1:DW] <= byte_wdata;
            end
        end

        // R6
        wb_apply_chk: assert property (@(posedge clk) disable iff (rst)
            (wb_i.en && wb_i.sel == psel_e'(g)) |=> (ptr_q[g] == $past(wb_i.value)));

        // R11
        wb_over_byte_chk: assert property (@(posedge clk) disable iff (rst)
            (wb_i.en && wb_i.sel == psel_e'(g) && byte_we &&
             (byte_idx == IDX_W'(LO_IDX) || byte_idx == IDX_W'(HI_IDX)))
            |=> (ptr_q[g] == $past(wb_i.value)));
    end

    // R10
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wb_i.en && !byte_we) |=> $stable(ptr_q));

endmodule

// File: rtl/dag_addr_calc.sv
module dag_addr_calc
    import dag_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     op_valid,
    input  logic [2:0]               op_mode,
    input  logic [1:0]               op_ptr,
    input  logic [IMM_W-1:0]         op_imm6,
    input  addr_t                    op_word2,
    input  logic [PTR_N-1:0][AW-1:0] ptr_q,
    output addr_t                    ea,
    output wb_t                      wb_o
);

    localparam addr_t ONE_A     = addr_t'(1);
    localparam addr_t IO_BASE_A = addr_t'(IO_BASE);

    addr_t base;
    addr_t imm_ext;

    always_comb begin
        case (op_ptr)
            PSEL_X:  base = ptr_q[0];
            PSEL_Y:  base = ptr_q[1];
            PSEL_Z:  base = ptr_q[2];
            default: base = '0;
        endcase
    end

    assign imm_ext = addr_t'(op_imm6);

    always_comb begin
        ea         = '0;
        wb_o.en    = 1'b0;
        wb_o.sel   = psel_e'(op_ptr);
        wb_o.value = base;
        case (op_mode)
            AM_DIRECT:  ea = op_word2;
            AM_IND:     ea = base;
            AM_DISP:    ea = base + imm_ext;
            AM_PREDEC: begin
                ea         = base - ONE_A;
                wb_o.en    = op_valid;
                wb_o.value = base - ONE_A;
            end
            AM_POSTINC: begin
                ea         = base;
                wb_o.en    = op_valid;
                wb_o.value = base + ONE_A;
            end
            AM_IODIR:   ea = IO_BASE_A + imm_ext;
            default:    ea = '0;
        endcase
    end

    // R5
    disp_base_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_mode == AM_DISP) |-> (op_ptr == PSEL_Y || op_ptr == PSEL_Z));

    // R4
    ptr_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && mode_uses_ptr(op_mode)) |-> (op_ptr != 2'd3));

    // R5
    disp_reach_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_mode == AM_DISP) |-> ((ea - base) < addr_t'(1 << IMM_W)));

    // R7
    postinc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_o.en && op_mode == AM_POSTINC) |-> (wb_o.value == ea + ONE_A));

    // R6
    predec_same_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_o.en && op_mode == AM_PREDEC) |-> (wb_o.value == ea));

    // R8
    io_window_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_mode == AM_IODIR) |->
        (ea >= IO_BASE_A && ea < addr_t'(SRAM_BASE)));

endmodule

// File: rtl/dag_region_dec.sv
module dag_region_dec
    import dag_pkg::*;
(
    input  addr_t   addr,
    output region_e region
);

    always_comb begin
        region = region_of(addr);
    end

endmodule

// File: rtl/data_addr_gen.sv
module data_addr_gen
    import dag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [2:0]  op_mode,
    input  logic [1:0]  op_ptr,
    input  logic [5:0]  op_imm6,
    input  logic [15:0] op_word2,
    input  logic        byte_we,
    input  logic [4:0]  byte_idx,
    input  logic [7:0]  byte_wdata,
    output logic [15:0] ea,
    output logic [1:0]  region,
    output logic        wb_en,
    output logic [1:0]  wb_ptr,
    output logic [15:0] wb_value
);

    logic [PTR_N-1:0][AW-1:0] ptr_q;
    wb_t                      wb;
    addr_t                    ea_w;
    region_e                  region_w;

    dag_ptr_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .byte_we    (byte_we),
        .byte_idx   (byte_idx),
        .byte_wdata (byte_wdata),
        .wb_i       (wb),
        .ptr_q      (ptr_q)
    );

    dag_addr_calc u_calc (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .op_mode  (op_mode),
        .op_ptr   (op_ptr),
        .op_imm6  (op_imm6),
        .op_word2 (op_word2),
        .ptr_q    (ptr_q),
        .ea       (ea_w),
        .wb_o     (wb)
    );

    dag_region_dec u_region (
        .addr   (ea_w),
        .region (region_w)
    );

    assign ea       = ea_w;
    assign region   = region_w;
    assign wb_en    = wb.en;
    assign wb_ptr   = wb.sel;
    assign wb_value = wb.value;

    // R9
    region_io_chk: assert property (@(posedge clk) disable iff (rst)
        (region == RG_IO) |-> (ea >= 16'h0020 && ea <= 16'h005F));

    // R9
    region_regs_chk: assert property (@(posedge clk) disable iff (rst)
        (ea < 16'h0020) |-> (region == RG_REGS));

    // R10
    idle_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> !wb_en);

    // R3
    direct_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (op_mode == AM_DIRECT || op_mode == AM_IND || op_mode == AM_DISP ||
         op_mode == AM_IODIR) |-> !wb_en);

endmodule

// File: tb/tb_data_addr_gen.sv
module tb_data_addr_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [2:0]  op_mode;
    logic [1:0]  op_ptr;
    logic [5:0]  op_imm6;
    logic [15:0] op_word2;
    logic        byte_we;
    logic [4:0]  byte_idx;
    logic [7:0]  byte_wdata;
    logic [15:0] ea;
    logic [1:0]  region;
    logic        wb_en;
    logic [1:0]  wb_ptr;
    logic [15:0] wb_value;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [15:0] mdl [3];

    always #5 clk = ~clk;

    data_addr_gen dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_mode(op_mode), .op_ptr(op_ptr),
        .op_imm6(op_imm6), .op_word2(op_word2), .byte_we(byte_we), .byte_idx(byte_idx),
        .byte_wdata(byte_wdata), .ea(ea), .region(region), .wb_en(wb_en),
        .wb_ptr(wb_ptr), .wb_value(wb_value)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_region(input logic [15:0] a);
        if (a <= 16'h001F) return 2'd0;
        if (a <= 16'h005F) return 2'd1;
        return 2'd2;
    endfunction

    task automatic idle_inputs();
        op_valid = 0; op_mode = 3'd1; op_ptr = 2'd0; op_imm6 = '0; op_word2 = '0;
        byte_we = 0; byte_idx = '0; byte_wdata = '0;
    endtask

    // One access cycle: drive at negedge, check outputs, update model after the edge.
    task automatic do_op(input string req, input logic v, input logic [2:0] m,
                         input logic [1:0] s, input logic [5:0] imm, input logic [15:0] w);
        logic [15:0] e_ea, e_wb;
        logic        e_en;
        @(negedge clk);
        op_valid = v; op_mode = m; op_ptr = s; op_imm6 = imm; op_word2 = w;
        #1;
        e_en = 0; e_wb = 16'h0;
        case (m)
            3'd0: e_ea = w;
            3'd1: e_ea = mdl[s];
            3'd2: e_ea = 16'(mdl[s] + {10'd0, imm});
            3'd3: begin e_ea = 16'(mdl[s] - 16'd1); e_en = v; e_wb = e_ea; end
            3'd4: begin e_ea = mdl[s]; e_en = v; e_wb = 16'(mdl[s] + 16'd1); end
            default: e_ea = 16'(16'h0020 + {10'd0, imm});
        endcase
        if (m <= 3'd5) begin
            chk({req, " ea"}, 32'(ea), 32'(e_ea));
            chk("R9 region", 32'(region), 32'(exp_region(e_ea)));
        end
        chk({req, " wb_en"}, 32'(wb_en), 32'(e_en));
        if (e_en) begin
            chk({req, " wb_ptr"}, 32'(wb_ptr), 32'(s));
            chk({req, " wb_value"}, 32'(wb_value), 32'(e_wb));
        end
        @(posedge clk);
        #1;
        if (e_en) mdl[s] = e_wb;
        idle_inputs();
    endtask

    task automatic wr_byte(input logic [4:0] idx, input logic [7:0] d);
        @(negedge clk);
        byte_we = 1; byte_idx = idx; byte_wdata = d;
        @(posedge clk);
        #1;
        if (idx >= 5'd26) begin
            if (idx[0]) mdl[(idx - 5'd26) >> 1][15:8] = d;
            else        mdl[(idx - 5'd26) >> 1][7:0]  = d;
        end
        idle_inputs();
    endtask

    task automatic load_ptr(input logic [1:0] s, input logic [15:0] val);
        wr_byte(5'(26 + 2 * s), val[7:0]);
        wr_byte(5'(27 + 2 * s), val[15:8]);
    endtask

    task automatic read_all(input string req);
        for (int s = 0; s < 3; s++) do_op(req, 1, 3'd1, 2'(s), 6'd0, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] bases [8];
        bases = '{16'h0000, 16'hFFFF, 16'h001F, 16'h0020, 16'h005F, 16'h0060, 16'hFFC1, 16'h8000};
        idle_inputs();
        for (int s = 0; s < 3; s++) mdl[s] = 16'h0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset pointers read back as zero
        read_all("R1");

        // R2: byte loads and off-range indices
        load_ptr(2'd0, 16'h1234);
        load_ptr(2'd1, 16'hABCD);
        load_ptr(2'd2, 16'h00FE);
        read_all("R2");
        wr_byte(5'd25, 8'h55);
        wr_byte(5'd0, 8'h77);
        wr_byte(5'd31, 8'h9C);
        read_all("R2");

        // R3 and R9: direct addresses across the map
        for (int i = 0; i < 256; i++) do_op("R3", 1, 3'd0, 2'(i % 3), 6'(i), 16'(i * 257 + i));
        for (int i = 0; i < 8; i++) do_op("R9", 1, 3'd0, 2'd0, 6'd0, bases[i]);

        // R8: every I/O address
        for (int i = 0; i < 64; i++) do_op("R8", 1, 3'd5, 2'd0, 6'(i), 16'hFFFF);

        // R5: every displacement on Y and Z over several bases
        for (int b = 0; b < 8; b++) begin
            for (int s = 1; s < 3; s++) begin
                load_ptr(2'(s), bases[b]);
                for (int i = 0; i < 64; i++) do_op("R5", 1, 3'd2, 2'(s), 6'(i), 16'h0);
                do_op("R5", 1, 3'd1, 2'(s), 6'd0, 16'h0);
            end
        end

        // R4, R6, R7: pointer modes on every pointer, including wrap points
        for (int b = 0; b < 8; b++) begin
            for (int s = 0; s < 3; s++) begin
                load_ptr(2'(s), bases[b]);
                do_op("R4", 1, 3'd1, 2'(s), 6'd0, 16'h0);
                do_op("R6", 1, 3'd3, 2'(s), 6'd0, 16'h0);
                do_op("R6", 1, 3'd3, 2'(s), 6'd0, 16'h0);
                do_op("R4", 1, 3'd1, 2'(s), 6'd0, 16'h0);
                do_op("R7", 1, 3'd4, 2'(s), 6'd0, 16'h0);
                do_op("R7", 1, 3'd4, 2'(s), 6'd0, 16'h0);
                do_op("R7", 1, 3'd4, 2'(s), 6'd0, 16'h0);
                do_op("R4", 1, 3'd1, 2'(s), 6'd0, 16'h0);
            end
        end
        read_all("R4");

        // R10: idle cycles with modifying modes do nothing
        load_ptr(2'd1, 16'h0000);
        do_op("R10", 0, 3'd3, 2'd1, 6'd0, 16'h0);
        do_op("R10", 0, 3'd4, 2'd1, 6'd0, 16'h0);
        do_op("R10", 0, 3'd7, 2'd3, 6'd0, 16'h0);
        read_all("R10");

        // R11: write-back and byte write on the same pointer in one cycle
        load_ptr(2'd2, 16'h4000);
        @(negedge clk);
        op_valid = 1; op_mode = 3'd4; op_ptr = 2'd2;
        byte_we = 1; byte_idx = 5'd30; byte_wdata = 8'hEE;
        #1;
        chk("R11 wb_value", 32'(wb_value), 32'h4001);
        @(posedge clk);
        #1;
        mdl[2] = 16'h4001;
        idle_inputs();
        do_op("R11", 1, 3'd1, 2'd2, 6'd0, 16'h0);
        // R11: byte write to another pointer still lands
        @(negedge clk);
        op_valid = 1; op_mode = 3'd3; op_ptr = 2'd2;
        byte_we = 1; byte_idx = 5'd27; byte_wdata = 8'h3C;
        @(posedge clk);
        #1;
        mdl[2] = 16'h4000;
        mdl[0][15:8] = 8'h3C;
        idle_inputs();
        read_all("R11");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule